// File: doc/BRIEF.md
# Converter Output Stage with Latency Alignment

This block is the digital back end of a pipelined analog-to-digital converter. A stub core hands it a corrected signed sample and an over-range flag. The block derives the sample rate by halving the master clock. It clamps each sample into the 14-bit two's-complement output range, delays the word so that it leaves exactly four sample periods after capture, and puts it on a parallel bus together with an out-of-range bit and a one-clock data-valid strobe.

The bus can be three-stated. Because no internal tristate buses are used, the block gives each data bit and the out-of-range bit an enable, alongside the data values. The strobe is never disabled by output enable. While the converter reports that calibration is busy, the strobe is held low. It also stays low for the first four samples after calibration ends, and for the first four samples after reset, so that stale pipeline contents are never reported as valid.

Strobe suppression is a three-state machine. `ST_RUN` passes strobes. `ST_CAL` is entered from any state whenever the busy input is high. `ST_CAL` moves to `ST_FLUSH` in the first cycle the busy input is low. `ST_FLUSH` counts four sample ticks and then moves to `ST_RUN`. Reset places the machine in `ST_FLUSH` with a count of zero.

Top module: `adc_out_stage`

## Requirements
- R1: After reset is released, a sample tick occurs on every second master clock edge. The first tick is the 2nd rising edge after release, so ticks fall on edges 2, 4, 6 and so on.
- R2: The word sampled from the raw inputs at one tick appears on `dout` right after the 4th following tick edge. It then stays unchanged until the next tick edge.
- R3: `dout` is two's complement with bit 13 as the MSB. A raw value above 8191 gives 0x1FFF. A raw value below -8192 gives 0x2000. Values from -8192 to 8191 pass through unchanged.
- R4: `dor` for a word is 1 exactly when that word's raw over-range flag was set or its value was clamped. It travels through the pipeline with the word.
- R5: With `oe` = 0, all `dout_oe` bits and `dor_oe` are 0, and `dout` and `dor` read 0. With `oe` = 1, all enables are 1 and the pipeline output is shown. The effect is immediate, with no register in between.
- R6: `dav` is high for exactly one master clock, in the cycle that follows a tick edge, and is never high in two consecutive cycles. `oe` has no effect on it.
- R7: If `cal_busy` is high at a tick edge, `dav` is low in the next cycle.
- R8: After `cal_busy` falls, and after reset, no `dav` is produced for the first four ticks. The fifth tick produces `dav`. After reset, the first `dav` therefore follows rising edge 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oe | input | 1 | Output enable for data and out-of-range bits |
| cal_busy | input | 1 | Calibration in progress, suppresses the strobe |
| raw_sample | input | 16 | Signed corrected sample from the core |
| raw_ovr | input | 1 | Over-range flag from the core |
| dout | output | 14 | Two's-complement output word |
| dout_oe | output | 14 | Per-bit drive enable for `dout` |
| dor | output | 1 | Out-of-range bit |
| dor_oe | output | 1 | Drive enable for `dor` |
| dav | output | 1 | Data-valid strobe, one master clock wide |

## Verification
On every cycle, the assertions check four things: the tick strictly alternates, the strobe is a single-clock pulse that always follows a tick, the strobe is suppressed after any busy cycle, and the bus word holds steady between ticks while it is enabled. Other behaviours can only be shown by the bench's scenarios against its reference queue. These are the exact four-tick alignment, the clamp values and `dor` marking at both full-scale edges, the five-tick recovery after calibration and after reset, and the independence of the strobe from `oe`.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;

    // Strobe suppression states
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CAL   = 2'd1,
        ST_FLUSH = 2'd2
    } sup_state_t;

endpackage

// File: rtl/adc_rate_div.sv
module adc_rate_div (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign tick = phase_q;

endmodule

// File: rtl/adc_sat_pipe.sv
module adc_sat_pipe #(
    parameter int RAW_W   = 16,
    parameter int DATA_W  = 14,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RAW_W-1:0]  raw_sample,
    input  logic              raw_ovr,
    output logic [DATA_W-1:0] word,
    output logic              word_ovr
);

    localparam int DEPTH = LATENCY + 1;
    localparam int MAX_I = (1 << (DATA_W - 1)) - 1;
    localparam int MIN_I = -(1 << (DATA_W - 1));

    int                raw_i;
    logic [DATA_W-1:0] clip_d;
    logic              clip_o;

    always_comb begin
        raw_i = int'($signed(raw_sample));
        if (raw_i > MAX_I) begin
            clip_d = DATA_W'(MAX_I);
            clip_o = 1'b1;
        end else if (raw_i < MIN_I) begin
            clip_d = DATA_W'(MIN_I);
            clip_o = 1'b1;
        end else begin
            clip_d = raw_i[DATA_W-1:0];
            clip_o = raw_ovr;
        end
    end

    logic [DATA_W-1:0] d_q [DEPTH];
    logic              o_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q[i] <= '0;
                    o_q[i] <= 1'b0;
                end else if (tick) begin
                    d_q[i] <= clip_d;
                    o_q[i] <= clip_o;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q[i] <= '0;
                    o_q[i] <= 1'b0;
                end else if (tick) begin
                    d_q[i] <= d_q[i-1];
                    o_q[i] <= o_q[i-1];
                end
            end
        end
    end

    assign word     = d_q[DEPTH-1];
    assign word_ovr = o_q[DEPTH-1];

endmodule

// File: rtl/adc_dav_ctrl.sv
module adc_dav_ctrl
    import adc_out_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cal_busy,
    output logic dav
);

    localparam int CNT_W = $clog2(LATENCY) + 1;

    sup_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dav_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cal_busy) begin
            state_d = ST_CAL;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    state_d = ST_RUN;
                end
                ST_CAL: begin
                    state_d = ST_FLUSH;
                    cnt_d   = '0;
                end
                ST_FLUSH: begin
                    if (tick) begin
                        if (cnt_q == CNT_W'(LATENCY - 1)) begin
                            state_d = ST_RUN;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_FLUSH;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dav_q <= 1'b0;
        end else begin
            dav_q <= tick && (state_q == ST_RUN) && !cal_busy;
        end
    end

    assign dav = dav_q;

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
    parameter int RAW_W   = 16,
    parameter int DATA_W  = 14,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe,
    input  logic              cal_busy,
    input  logic [RAW_W-1:0]  raw_sample,
    input  logic              raw_ovr,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_oe,
    output logic              dor,
    output logic              dor_oe,
    output logic              dav
);

    logic              tick_w;
    logic [DATA_W-1:0] word_w;
    logic              word_ovr_w;

    adc_rate_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w)
    );

    adc_sat_pipe #(
        .RAW_W   (RAW_W),
        .DATA_W  (DATA_W),
        .LATENCY (LATENCY)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .raw_sample (raw_sample),
        .raw_ovr    (raw_ovr),
        .word       (word_w),
        .word_ovr   (word_ovr_w)
    );

    adc_dav_ctrl #(
        .LATENCY (LATENCY)
    ) u_dav (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .cal_busy (cal_busy),
        .dav      (dav)
    );

    // Three-state modelled as enable plus value
    always_comb begin
        dout_oe = {DATA_W{oe}};
        dor_oe  = oe;
        dout    = oe ? word_w : '0;
        dor     = oe & word_ovr_w;
    end

endmodule

// File: rtl/adc_out_stage_chk.sv
module adc_out_stage_chk #(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe,
    input logic              cal_busy,
    input logic              tick,
    input logic              dav,
    input logic [DATA_W-1:0] dout
);

    // R1: tick strictly alternates
    assert_tick_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_tick_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> tick);

    // R2: enabled bus word holds between ticks
    assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(tick)) |-> $stable(dout));

    // R6: strobe is a single clock following a tick
    assert_dav_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dav |=> !dav);
    assert_dav_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dav |-> $past(tick));

    // R7: busy suppresses the strobe
    assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |=> !dav);

    // R8: end of busy enters the flush window
    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |=> !dav);

endmodule

bind adc_out_stage adc_out_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe       (oe),
    .cal_busy (cal_busy),
    .tick     (tick_w),
    .dav      (dav),
    .dout     (dout)
);

// File: tb/tb_adc_out_stage.sv
`timescale 1ns/1ps
module tb_adc_out_stage;

    localparam int RAW_W   = 16;
    localparam int DATA_W  = 14;
    localparam int LAT     = 4;
    localparam int S_RUN   = 0;
    localparam int S_CAL   = 1;
    localparam int S_FLUSH = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              oe;
    logic              cal_busy;
    logic [RAW_W-1:0]  raw_sample;
    logic              raw_ovr;
    logic [DATA_W-1:0] dout;
    logic [DATA_W-1:0] dout_oe;
    logic              dor;
    logic              dor_oe;
    logic              dav;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    adc_out_stage dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .oe         (oe),
        .cal_busy   (cal_busy),
        .raw_sample (raw_sample),
        .raw_ovr    (raw_ovr),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .dor        (dor),
        .dor_oe     (dor_oe),
        .dav        (dav)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Clamp rule from R3 / R4
    function automatic logic [DATA_W-1:0] clamp_val(input int r);
        if (r > 8191)  return 14'h1FFF;
        if (r < -8192) return 14'h2000;
        return r[DATA_W-1:0];
    endfunction

    function automatic bit clamp_hit(input int r);
        return (r > 8191) || (r < -8192);
    endfunction

    // Reference built from R1, R2, R6-R8
    logic [DATA_W-1:0] m_d [LAT+1];
    bit                m_o [LAT+1];
    bit                m_c [LAT+1];
    bit                m_ph;
    int                m_st;
    int                m_cnt;
    bit                m_dav;
    int                pos_cnt;
    int                first_dav;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_st = S_FLUSH; m_cnt = 0; m_dav = 0;
            pos_cnt = 0; first_dav = 0;
            for (int i = 0; i <= LAT; i++) begin
                m_d[i] = '0; m_o[i] = 0; m_c[i] = 0;
            end
        end else begin
            bit tk;
            int r;
            pos_cnt++;
            tk = m_ph;
            m_ph = !m_ph;
            m_dav = tk && (m_st == S_RUN) && !cal_busy;
            if (m_dav && first_dav == 0) first_dav = pos_cnt;
            if (cal_busy) begin
                m_st = S_CAL; m_cnt = 0;
            end else if (m_st == S_CAL) begin
                m_st = S_FLUSH; m_cnt = 0;
            end else if (m_st == S_FLUSH && tk) begin
                if (m_cnt == LAT - 1) begin m_st = S_RUN; m_cnt = 0; end
                else m_cnt++;
            end
            if (tk) begin
                for (int i = LAT; i > 0; i--) begin
                    m_d[i] = m_d[i-1]; m_o[i] = m_o[i-1]; m_c[i] = m_c[i-1];
                end
                r = int'($signed(raw_sample));
                m_d[0] = clamp_val(r);
                m_c[0] = clamp_hit(r);
                m_o[0] = clamp_hit(r) | raw_ovr;
            end
        end
    end

    // Continuous comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [DATA_W-1:0] ed;
            ed = oe ? m_d[LAT] : '0;
            chk(m_c[LAT] ? "R3" : "R2", dout == ed, dout, ed);
            chk("R4", dor == (oe & m_o[LAT]), dor, oe & m_o[LAT]);
            chk("R5", (dout_oe == {DATA_W{oe}}) && (dor_oe == oe),
                {dor_oe, dout_oe}, {oe, {DATA_W{oe}}});
            chk(cal_busy ? "R7" : (m_st == S_FLUSH ? "R8" : "R6"),
                dav == m_dav, dav, m_dav);
        end
    end

    initial begin
        #800000;
        fails++;
        checks++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int burst;
        void'($urandom(32'd4242));
        rst_n = 0; oe = 1; cal_busy = 0; raw_sample = '0; raw_ovr = 0;
        repeat (3) @(negedge clk);
        // Reset state (R5, R6)
        chk("R5", dout == '0 && dor == 1'b0, dout, 0);
        chk("R6", dav == 1'b0, dav, 0);
        #1 rst_n = 1;

        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1 raw_sample = RAW_W'($urandom_range(0, 8000));
        end
        // R1 and R8: first strobe follows rising edge 10
        chk("R1", first_dav == 10, first_dav, 10);
        chk("R8", first_dav == 10, first_dav, 10);

        // Directed clamp corners (R3, R4)
        begin
            int vals [6] = '{32767, -32768, 8191, -8192, 8192, -8193};
            logic [DATA_W-1:0] exp_d [6] = '{14'h1FFF, 14'h2000, 14'h1FFF, 14'h2000, 14'h1FFF, 14'h2000};
            bit exp_o [6] = '{1, 1, 0, 0, 1, 1};
            for (int k = 0; k < 6; k++) begin
                @(negedge clk); #1 raw_sample = RAW_W'(vals[k]); raw_ovr = 0;
                repeat (12) @(negedge clk);
                chk("R3", dout == exp_d[k], dout, exp_d[k]);
                chk("R4", dor == exp_o[k], dor, exp_o[k]);
            end
        end

        // Output enable off then on (R5)
        @(negedge clk); #1 oe = 0;
        @(negedge clk);
        chk("R5", dout == '0 && dout_oe == '0 && !dor_oe, dout_oe, 0);
        #1 oe = 1;

        // Random phase with busy pulses of both parities
        burst = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            case ($urandom_range(0, 3))
                0:       raw_sample = RAW_W'($urandom);
                default: raw_sample = RAW_W'(int'($urandom_range(0, 16383)) - 8192);
            endcase
            raw_ovr = ($urandom_range(0, 15) == 0);
            oe      = ($urandom_range(0, 7) != 0);
            if (burst > 0) begin
                burst--;
                cal_busy = (burst != 0);
            end else if ($urandom_range(0, 99) == 0) begin
                burst = $urandom_range(2, 25);
                cal_busy = 1;
            end else begin
                cal_busy = 0;
            end
        end

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule